// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block decides the moment at which an analog-to-digital conversion begins. A conversion can be requested in two ways. Software can write a start register, or an edge can arrive on an asynchronous trigger pin. The pin is first passed through a two-flop synchronizer. A control register chooses the source and the edge polarity. In external mode it also chooses between free-running operation, where every qualified edge counts, and a one-shot mode, where software arms the block before each accepted edge.

Once a trigger is accepted, the block waits for a programmable number of timebase ticks and then issues a single-cycle `conv_start` pulse. The tick comes from a prescaler that divides the clock by (divisor field + 1). The block then stays busy until the converter reports `conv_done`. Triggers that arrive while a delay or a conversion is pending are discarded. A five-bit fine-delay field is held in the delay register and driven out as is, for use by an external clock-delay element.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, `conv_start` is 0, the block is idle and unarmed, all configuration fields are 0, and `fine_dly` reads 0.
- R2: A write with `wr_sel`=0 loads the control bits from `wr_data`: bit 0 is polarity, bit 1 is external mode and bit 2 is automatic mode. A write with `wr_sel`=1 is a start request, whatever the data. A write with `wr_sel`=2 loads the delay register: bits 15:14 are the divisor, bits 13:5 are the delay count and bits 4:0 are the fine delay. `fine_dly` shows bits 4:0 one cycle after the write.
- R3: With external mode 0, every start request accepted while idle launches a conversion. The trigger pin and the automatic bit have no effect in this mode.
- R4: With polarity 0 only rising pin edges qualify, and with polarity 1 only falling edges qualify. A pin change takes two synchronizer stages plus one edge-detect stage to be accepted.
- R5: With external=1 and automatic=1, every qualified edge that arrives while the block is idle launches a conversion, and no start request is needed.
- R6: With external=1 and automatic=0, a start request only arms the block and does not launch a conversion. While armed, one qualified edge launches a conversion. The `conv_done` that completes that conversion disarms the block. An edge that arrives while the block is unarmed is ignored.
- R7: With divisor n and delay count D, `conv_start` rises 1 + D·(n+1) clock edges after the edge that accepts a start request. For a pin trigger it rises 3 + D·(n+1) edges after the edge that first samples the changed pin level.
- R8: `conv_start` is high for exactly one cycle. No further conversion starts until `conv_done` has been seen.
- R9: A trigger that arrives while a delay or a conversion is pending is dropped and causes no additional pulse.
- R10: A delay count of 0 issues `conv_start` on the cycle right after the trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the clock that the prescaler divides |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 start, 2 delay |
| wr_data | input | 16 | Write data |
| trig_pin | input | 1 | Asynchronous external trigger |
| conv_done | input | 1 | Converter reports the conversion finished |
| conv_start | output | 1 | One-cycle start-of-conversion pulse |
| fine_dly | output | 5 | Stored fine-delay field |

## Verification
The bench uses the default parameters: a 2-bit divisor, a 9-bit delay count, a 5-bit fine field and two synchronizer stages. With these widths, random divisor and count settings cover every divide ratio. A directed case runs at the longest setting, 511 ticks at divide-by-4, so the count passes through its full range. The small widths keep even the longest delay to about two thousand cycles, so every latency can be measured exactly to the cycle.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUSY = 2'd2
  } seq_state_e;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_START = 2'd1;
  localparam logic [1:0] SEL_DELAY = 2'd2;

  localparam int CTRL_POL  = 0;
  localparam int CTRL_EXT  = 1;
  localparam int CTRL_AUTO = 2;
  localparam int CTRL_W    = 3;
endpackage

// File: rtl/adc_pin_edge.sv
module adc_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic falling,
  output logic hit
);
  logic [STAGES:0] shreg;
  logic            synced;
  logic            prev;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-1:0], pin};
  end

  assign synced = shreg[STAGES-1];
  assign prev   = shreg[STAGES];
  assign hit    = falling ? (prev & ~synced) : (synced & ~prev);

  // R4: a level change yields one detect cycle unless polarity flips
  a_r4_single_hit: assert property (@(posedge clk) disable iff (rst)
    hit |=> (!hit || falling != $past(falling)));
endmodule

// File: rtl/adc_dly_timer.sv
module adc_dly_timer #(
  parameter int DIV_W = 2,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [DIV_W-1:0] div,
  input  logic             run,
  output logic             expire
);
  logic [DIV_W-1:0] pcnt;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick   = (pcnt >= div);
  assign expire = run && tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
      cnt  <= '0;
    end else if (load) begin
      pcnt <= '0;
      cnt  <= load_val;
    end else if (run) begin
      if (tick) begin
        pcnt <= '0;
        cnt  <= cnt - CNT_W'(1);
      end else begin
        pcnt <= pcnt + DIV_W'(1);
      end
    end
  end

  // R7: while waiting, ticks remain to be counted
  a_r7_cnt_live: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt != '0);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_trig_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sw_start,
  input  logic ext_mode,
  input  logic auto_mode,
  input  logic edge_hit,
  input  logic dly_zero,
  input  logic expire,
  input  logic conv_done,
  output logic load,
  output logic run,
  output logic conv_start
);
  seq_state_e state;
  logic       armed;
  logic       trig;

  assign trig = (state == ST_IDLE) &&
                (ext_mode ? (edge_hit && (auto_mode || armed)) : sw_start);
  assign load = trig && !dly_zero;
  assign run  = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      armed      <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      case (state)
        ST_IDLE: if (trig) begin
          if (dly_zero) begin
            conv_start <= 1'b1;
            state      <= ST_BUSY;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: if (expire) begin
          conv_start <= 1'b1;
          state      <= ST_BUSY;
        end
        ST_BUSY: if (conv_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (state == ST_BUSY && conv_done)       armed <= 1'b0;
      else if (sw_start && ext_mode && !auto_mode) armed <= 1'b1;
    end
  end

  // R8: pulse is one cycle wide
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  // R8: a pulse always coincides with the busy state
  a_r8_busy_with_start: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> state == ST_BUSY);
  // R6: arming only comes from a start request in one-shot external mode
  a_r6_arm_source: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(sw_start && ext_mode && !auto_mode));
  // R6: disarming only on completion of a conversion
  a_r6_disarm_source: assert property (@(posedge clk) disable iff (rst)
    $fell(armed) |-> $past(state == ST_BUSY && conv_done));
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_trig_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DIV_W       = 2,
  parameter int DLY_W       = 9,
  parameter int FINE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trig_pin,
  input  logic              conv_done,
  output logic              conv_start,
  output logic [FINE_W-1:0] fine_dly
);
  localparam int DLY_LSB  = FINE_W;
  localparam int DIV_LSB  = FINE_W + DLY_W;
  localparam int REG_USED = DIV_LSB + DIV_W;

  logic [CTRL_W-1:0]   ctrl_q;
  logic [REG_USED-1:0] dly_q;
  logic                sw_start;
  logic                edge_hit;
  logic                load;
  logic                run;
  logic                expire;
  logic [DLY_W-1:0]    dly_cnt;
  logic [DIV_W-1:0]    div;

  generate
    if (DATA_W > REG_USED) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:REG_USED];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      dly_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_CTRL)  ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_sel == SEL_DELAY) dly_q  <= wr_data[REG_USED-1:0];
    end
  end

  assign sw_start = wr_en && (wr_sel == SEL_START);
  assign dly_cnt  = dly_q[DLY_LSB +: DLY_W];
  assign div      = dly_q[DIV_LSB +: DIV_W];
  assign fine_dly = dly_q[FINE_W-1:0];

  adc_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin(trig_pin),
    .falling(ctrl_q[CTRL_POL]), .hit(edge_hit)
  );

  adc_dly_timer #(.DIV_W(DIV_W), .CNT_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(dly_cnt),
    .div(div), .run(run), .expire(expire)
  );

  adc_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sw_start(sw_start),
    .ext_mode(ctrl_q[CTRL_EXT]), .auto_mode(ctrl_q[CTRL_AUTO]),
    .edge_hit(edge_hit), .dly_zero(dly_cnt == '0), .expire(expire),
    .conv_done(conv_done), .load(load), .run(run), .conv_start(conv_start)
  );

  // R1: fine field register comes out of reset cleared
  a_r1_fine_reset: assert property (@(posedge clk)
    rst |=> fine_dly == '0);
endmodule

// File: tb/test_adc_trig_seq.sv
module test_adc_trig_seq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        trig_pin;
  logic        conv_done;
  logic        conv_start;
  logic [4:0]  fine_dly;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_trig_seq i_adc_trig_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .trig_pin(trig_pin), .conv_done(conv_done),
    .conv_start(conv_start), .fine_dly(fine_dly)
  );

  function automatic int lat(bit from_pin, int d, int n);
    return (from_pin ? 3 : 1) + d * (n + 1);
  endfunction

  function automatic logic [15:0] dly_word(int n, int d, int f);
    return 16'((n << 14) | (d << 5) | f);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Watch for a window after stimulus driven at the current negedge.
  // exp < 0 means no pulse is expected. poke > 0 issues another start write then.
  task automatic observe(int exp, int window, int poke, string req);
    int first = 0, pulses = 0;
    bit prev = 1'b0, wide = 1'b0;
    for (int k = 1; k <= window; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      conv_done = 1'b0;
      if (k == poke) begin
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'hA5A5;
      end
      if (conv_start) begin
        pulses++;
        if (first == 0) first = k;
        if (prev) wide = 1'b1;
        conv_done = 1'b1;
      end
      prev = conv_start;
    end
    @(negedge clk);
    wr_en = 1'b0;
    conv_done = 1'b0;
    if (exp < 0) begin
      check(pulses == 0, req, pulses, 0);
    end else begin
      check(first == exp, req, first, exp);
      check(pulses == 1 && !wide, {req, "/R8"}, pulses, 1);
    end
  endtask

  task automatic sw_fire(int exp, int poke, string req);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'($urandom);
    observe(exp, (exp < 0 ? 12 : exp + 6), poke, req);
  endtask

  task automatic pin_fire(logic lvl, int exp, int win, string req);
    @(negedge clk);
    trig_pin = lvl;
    observe(exp, win, 0, req);
  endtask

  initial begin
    int n, d;
    void'($urandom(32'd20240611));
    rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    trig_pin = 1'b0; conv_done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(conv_start == 1'b0, "R1", conv_start, 0);
    check(fine_dly == 5'd0, "R1", fine_dly, 0);

    // R2 fine field placement
    wr(2'd2, dly_word(0, 0, 5'd19));
    check(fine_dly == 5'd19, "R2", fine_dly, 19);
    wr(2'd0, 16'h0000);

    // R10 zero delay and R3 software start
    sw_fire(lat(0, 0, 0), 0, "R10");

    // R7 random divisor / count with software start
    for (int i = 0; i < 16; i++) begin
      n = $urandom_range(0, 3);
      d = $urandom_range(0, 40);
      wr(2'd2, dly_word(n, d, $urandom_range(0, 31)));
      sw_fire(lat(0, d, n), 0, "R7");
    end
    // R7 longest delay
    wr(2'd2, dly_word(3, 511, 0));
    sw_fire(lat(0, 511, 3), 0, "R7");

    // R9 second request during the delay is dropped
    wr(2'd2, dly_word(0, 10, 0));
    sw_fire(lat(0, 10, 0), 4, "R9");

    // R3 pin ignored in software mode, also with automatic bit set
    wr(2'd2, dly_word(1, 2, 0));
    pin_fire(1'b1, -1, 15, "R3");
    pin_fire(1'b0, -1, 15, "R3");
    wr(2'd0, 16'h0004);
    pin_fire(1'b1, -1, 15, "R3");
    pin_fire(1'b0, -1, 15, "R3");
    sw_fire(lat(0, 2, 1), 0, "R3");

    // R5/R4 automatic external, rising polarity
    wr(2'd0, 16'h0006);
    for (int i = 0; i < 6; i++) begin
      n = $urandom_range(0, 3);
      d = $urandom_range(0, 12);
      wr(2'd2, dly_word(n, d, 0));
      pin_fire(1'b1, lat(1, d, n), lat(1, d, n) + 6, "R5");
      pin_fire(1'b0, -1, lat(1, d, n) + 6, "R4");
    end
    // R5 start write has no effect in automatic external mode
    sw_fire(-1, 0, "R5");

    // R4 falling polarity
    wr(2'd0, 16'h0007);
    wr(2'd2, dly_word(2, 3, 0));
    pin_fire(1'b1, -1, 20, "R4");
    pin_fire(1'b0, lat(1, 3, 2), 20, "R4");
    pin_fire(1'b1, -1, 20, "R4");
    pin_fire(1'b0, lat(1, 3, 2), 20, "R4");

    // R6 one-shot external mode, rising polarity
    pin_fire(1'b0, -1, 6, "R6");
    wr(2'd0, 16'h0002);
    pin_fire(1'b1, -1, 20, "R6");
    pin_fire(1'b0, -1, 6, "R6");
    sw_fire(-1, 0, "R6");
    pin_fire(1'b1, lat(1, 3, 2), 20, "R6");
    pin_fire(1'b0, -1, 6, "R6");
    pin_fire(1'b1, -1, 20, "R6");
    pin_fire(1'b0, -1, 6, "R6");
    sw_fire(-1, 0, "R6");
    pin_fire(1'b1, lat(1, 3, 2), 20, "R6");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule